// File: doc/BRIEF.md
# GPU command stream decoder

The decoder takes a stream of 32-bit command words on a valid/ready input. Each command begins with a header word that names a base method, a subchannel, a word count (or a 13-bit immediate) and a submission mode. The mode decides how the method number moves across the argument words that follow the header. Every argument, and every inline immediate, becomes one register write made of a method number, a subchannel and a 32-bit value.

Each write is handled according to its method. Method 0 binds its subchannel to an engine class ID, taken from the low 16 bits of the value. Methods 1 to 0xFF are reserved: they are reported and dropped. Methods 0x100 and above go to the engine whose class is bound to the write's subchannel. Each engine has its own valid/ready write port. All engine ports share one method bus and one value bus. While a write waits for its engine to accept it, the decoder takes no more input words.

The sequencer has three states. ST_HDR waits for a header and moves to ST_ARG when argument words follow, or to ST_ISSUE for an inline header. For a bad mode, an empty count or an increment-once header with count 0, it stays in ST_HDR. ST_ARG accepts one argument word and moves to ST_ISSUE. ST_ISSUE presents the pending write. When the write completes, it returns to ST_ARG if arguments remain and to ST_HDR if none do.

Top module: `cmd_stream_decoder`

## Requirements
- R1: A header has the base method in bits 12:0, the subchannel in bits 15:13, the count or immediate in bits 28:16 and the mode in bits 31:29. In modes 0 and 1, argument i is written to method (base+i) modulo 2^13. A count of 0 in modes 0 to 3 produces no write, and the next word is taken as a header.
- R2: In modes 2 and 3, every argument is written to the base method.
- R3: In mode 5, the first argument goes to the base method and every later argument goes to base+1. A mode-5 header with count 0 pulses err_zero_count for one cycle and produces no write.
- R4: In mode 4, no argument words are consumed. One write is made to the base method, with the value set to the 13-bit immediate from bits 28:16, zero-extended.
- R5: A write to method 0 on an unbound subchannel binds that subchannel to class value[15:0]. It reaches no engine port and raises no flag.
- R6: A write to method 0 on a subchannel that is already bound pulses err_rebind for one cycle. The existing binding is kept.
- R7: A write to a method from 1 to 0xFF pulses err_reserved for one cycle and reaches no engine port.
- R8: A write to a method of 0x100 or above goes only to the port of the bound engine: bit 0 for class 0x902D, bit 1 for 0xB197, bit 2 for 0xB1C0. The port carries the method and value on eng_method and eng_value.
- R9: A write to a method of 0x100 or above is dropped with a one-cycle flag in two cases. On an unbound subchannel the flag is err_unbound. On a subchannel bound to any other class the flag is err_bad_class.
- R10: A header with mode 6 or 7 pulses err_bad_mode for one cycle, produces no write, and the following word is taken as a header.
- R11: While an engine valid is high and its ready is low, eng_valid, eng_method and eng_value hold steady and in_ready is low.
- R12: Synchronous reset clears every binding, ends any command in progress, and leaves in_ready high with every engine valid and flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Command word valid |
| in_ready | output | 1 | Decoder can take a command word |
| in_word | input | 32 | Command word (header or argument) |
| eng_valid | output | 3 | Per-engine write valid (bit 0 = 2D, bit 1 = 3D, bit 2 = compute) |
| eng_ready | input | 3 | Per-engine write accept |
| eng_method | output | 13 | Method number of the presented write |
| eng_value | output | 32 | Value of the presented write |
| err_bad_mode | output | 1 | Pulse: header with mode 6 or 7 |
| err_zero_count | output | 1 | Pulse: increment-once header with count 0 |
| err_rebind | output | 1 | Pulse: bind on an already bound subchannel |
| err_reserved | output | 1 | Pulse: write to a reserved method |
| err_unbound | output | 1 | Pulse: engine write on an unbound subchannel |
| err_bad_class | output | 1 | Pulse: engine write on a subchannel bound to an unknown class |

## Verification
The bench targets several corner cases, each of which shows up as a wrong method at an engine port or as a missing or misplaced flag:
- An incrementing run that starts at 0xFE crosses from reserved methods into engine methods. A decoder that classifies the base method instead of each write's own method would forward or drop the wrong words.
- Increment-once commands with counts of 1, 4 and 0. A decoder that kept incrementing would put the later arguments on base+2 and above.
- Inline headers. A decoder that consumed an argument word after an inline header would swallow the next header.
- A rebind of a bound subchannel. A decoder that overwrote the binding would send later writes to the wrong engine.
- Random engine back-pressure throughout the run. It catches a decoder that changes the presented write or accepts input before the engine takes the write.
- A reset in the middle of a command. It shows whether stale bindings or argument counts survive the reset.

// File: rtl/csd_pkg.sv
package csd_pkg;
    localparam int WORD_W     = 32;
    localparam int METH_W     = 13;
    localparam int SUB_W      = 3;
    localparam int CNT_W      = 13;
    localparam int MODE_W     = 3;
    localparam int CLASS_W    = 16;
    localparam int NUM_ENG    = 3;
    localparam int NUM_SUB    = 1 << SUB_W;
    localparam int RESV_LIMIT = 256;

    typedef enum logic [MODE_W-1:0] {
        MD_INC_A  = 3'd0,
        MD_INC_B  = 3'd1,
        MD_FIX_A  = 3'd2,
        MD_FIX_B  = 3'd3,
        MD_IMM    = 3'd4,
        MD_ONCE   = 3'd5,
        MD_BAD_6  = 3'd6,
        MD_BAD_7  = 3'd7
    } sub_mode_e;

    typedef enum logic [1:0] {
        ST_HDR   = 2'd0,
        ST_ARG   = 2'd1,
        ST_ISSUE = 2'd2
    } seq_state_e;

    function automatic logic [CLASS_W-1:0] eng_class(input int k);
        case (k)
            0:       return 16'h902D;
            1:       return 16'hB197;
            default: return 16'hB1C0;
        endcase
    endfunction
endpackage

// File: rtl/csd_bind_table.sv
module csd_bind_table
    import csd_pkg::*;
#(
    parameter int N_SUB = NUM_SUB,
    parameter int S_W   = SUB_W,
    parameter int C_W   = CLASS_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [S_W-1:0] wsub,
    input  logic [C_W-1:0] wclass,
    input  logic [S_W-1:0] rsub,
    output logic           bound,
    output logic [C_W-1:0] rclass,
    output logic           conflict
);
    logic [N_SUB-1:0] vld;
    logic [C_W-1:0]   cls [N_SUB];

    for (genvar s = 0; s < N_SUB; s++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                vld[s] <= 1'b0;
                cls[s] <= '0;
            end else if (we && wsub == S_W'(s) && !vld[s]) begin
                vld[s] <= 1'b1;
                cls[s] <= wclass;
            end
        end
    end

    assign bound    = vld[rsub];
    assign rclass   = cls[rsub];
    assign conflict = we && vld[wsub];

    a_r5_bind_takes: assert property (@(posedge clk) disable iff (rst)
        (we && !vld[wsub]) |=> (vld[$past(wsub)] && cls[$past(wsub)] == $past(wclass)));

    a_r6_rebind_keeps: assert property (@(posedge clk) disable iff (rst)
        (we && vld[wsub]) |=> (cls[$past(wsub)] == $past(cls[wsub])));
endmodule

// File: rtl/csd_class_match.sv
module csd_class_match
    import csd_pkg::*;
#(
    parameter int N_ENG = NUM_ENG,
    parameter int C_W   = CLASS_W
) (
    input  logic [C_W-1:0]   cls,
    output logic [N_ENG-1:0] hit_vec,
    output logic             hit
);
    for (genvar k = 0; k < N_ENG; k++) begin : g_cmp
        assign hit_vec[k] = (cls == C_W'(eng_class(k)));
    end
    assign hit = |hit_vec;
endmodule

// File: rtl/csd_sequencer.sv
module csd_sequencer
    import csd_pkg::*;
#(
    parameter int W_W = WORD_W,
    parameter int M_W = METH_W,
    parameter int S_W = SUB_W,
    parameter int N_W = CNT_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [W_W-1:0] in_word,
    output logic           in_ready,
    input  logic           issue_done,
    output logic           issue,
    output logic [M_W-1:0] pend_method,
    output logic [S_W-1:0] pend_sub,
    output logic [W_W-1:0] pend_value,
    output logic           err_mode,
    output logic           err_zero
);
    localparam int SUB_LO  = M_W;
    localparam int CNT_LO  = M_W + S_W;
    localparam int MODE_LO = M_W + S_W + N_W;

    seq_state_e state, nxt;
    sub_mode_e  mode_r, h_mode;
    logic [M_W-1:0] base_r, h_meth, gen_meth;
    logic [S_W-1:0] sub_r, h_sub;
    logic [N_W-1:0] h_cnt, left_r, idx_r;
    logic accept;

    assign h_meth = in_word[M_W-1:0];
    assign h_sub  = in_word[SUB_LO +: S_W];
    assign h_cnt  = in_word[CNT_LO +: N_W];
    assign h_mode = sub_mode_e'(in_word[MODE_LO +: MODE_W]);
    assign accept = in_valid && in_ready;

    always_comb begin
        unique case (mode_r)
            MD_INC_A, MD_INC_B: gen_meth = base_r + idx_r[M_W-1:0];
            MD_ONCE:            gen_meth = (idx_r == '0) ? base_r : base_r + M_W'(1);
            default:            gen_meth = base_r;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_HDR;
        else     state <= nxt;
    end

    // next state and outputs
    always_comb begin
        nxt      = state;
        in_ready = 1'b0;
        issue    = 1'b0;
        unique case (state)
            ST_HDR: begin
                in_ready = 1'b1;
                if (accept) begin
                    unique case (h_mode)
                        MD_INC_A, MD_INC_B, MD_FIX_A, MD_FIX_B, MD_ONCE:
                            nxt = (h_cnt == '0) ? ST_HDR : ST_ARG;
                        MD_IMM:
                            nxt = ST_ISSUE;
                        MD_BAD_6, MD_BAD_7:
                            nxt = ST_HDR;
                    endcase
                end
            end
            ST_ARG: begin
                in_ready = 1'b1;
                if (accept) nxt = ST_ISSUE;
            end
            ST_ISSUE: begin
                issue = 1'b1;
                if (issue_done) nxt = (left_r == '0) ? ST_HDR : ST_ARG;
            end
            default: nxt = ST_HDR;
        endcase
    end

    // command datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_r      <= MD_INC_A;
            base_r      <= '0;
            sub_r       <= '0;
            left_r      <= '0;
            idx_r       <= '0;
            pend_method <= '0;
            pend_sub    <= '0;
            pend_value  <= '0;
            err_mode    <= 1'b0;
            err_zero    <= 1'b0;
        end else begin
            err_mode <= (state == ST_HDR) && accept &&
                        (h_mode == MD_BAD_6 || h_mode == MD_BAD_7);
            err_zero <= (state == ST_HDR) && accept && h_mode == MD_ONCE && h_cnt == '0;
            if (state == ST_HDR && accept) begin
                mode_r <= h_mode;
                base_r <= h_meth;
                sub_r  <= h_sub;
                idx_r  <= '0;
                if (h_mode == MD_IMM) begin
                    left_r      <= '0;
                    pend_method <= h_meth;
                    pend_sub    <= h_sub;
                    pend_value  <= {{(W_W-N_W){1'b0}}, h_cnt};
                end else begin
                    left_r <= h_cnt;
                end
            end else if (state == ST_ARG && accept) begin
                pend_method <= gen_meth;
                pend_sub    <= sub_r;
                pend_value  <= in_word;
                idx_r       <= idx_r + N_W'(1);
                left_r      <= left_r - N_W'(1);
            end
        end
    end

    a_r10_bad_mode_to_hdr: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HDR && accept && (h_mode == MD_BAD_6 || h_mode == MD_BAD_7))
        |=> (state == ST_HDR && err_mode));

    a_r4_inline_issue: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HDR && accept && h_mode == MD_IMM)
        |=> (state == ST_ISSUE && pend_value == {{(W_W-N_W){1'b0}}, $past(h_cnt)}));

    a_r3_once_second_arg: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARG && accept && mode_r == MD_ONCE && idx_r != '0)
        |=> (pend_method == $past(base_r) + M_W'(1)));
endmodule

// File: rtl/cmd_stream_decoder.sv
module cmd_stream_decoder
    import csd_pkg::*;
#(
    parameter int W_W   = WORD_W,
    parameter int M_W   = METH_W,
    parameter int S_W   = SUB_W,
    parameter int C_W   = CLASS_W,
    parameter int N_ENG = NUM_ENG
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [W_W-1:0]   in_word,
    output logic [N_ENG-1:0] eng_valid,
    input  logic [N_ENG-1:0] eng_ready,
    output logic [M_W-1:0]   eng_method,
    output logic [W_W-1:0]   eng_value,
    output logic             err_bad_mode,
    output logic             err_zero_count,
    output logic             err_rebind,
    output logic             err_reserved,
    output logic             err_unbound,
    output logic             err_bad_class
);
    localparam int N_SUB = 1 << S_W;

    logic           issue, issue_done;
    logic [M_W-1:0] pend_method;
    logic [S_W-1:0] pend_sub;
    logic [W_W-1:0] pend_value;
    logic           is_bind, is_resv, is_eng;
    logic           bound, hit, conflict;
    logic [C_W-1:0] bound_cls;
    logic [N_ENG-1:0] hit_vec;

    csd_sequencer #(.W_W(W_W), .M_W(M_W), .S_W(S_W), .N_W(CNT_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_word     (in_word),
        .in_ready    (in_ready),
        .issue_done  (issue_done),
        .issue       (issue),
        .pend_method (pend_method),
        .pend_sub    (pend_sub),
        .pend_value  (pend_value),
        .err_mode    (err_bad_mode),
        .err_zero    (err_zero_count)
    );

    assign is_bind = (pend_method == '0);
    assign is_resv = !is_bind && (pend_method < M_W'(RESV_LIMIT));
    assign is_eng  = !is_bind && !is_resv;

    csd_bind_table #(.N_SUB(N_SUB), .S_W(S_W), .C_W(C_W)) u_bind (
        .clk      (clk),
        .rst      (rst),
        .we       (issue && is_bind),
        .wsub     (pend_sub),
        .wclass   (pend_value[C_W-1:0]),
        .rsub     (pend_sub),
        .bound    (bound),
        .rclass   (bound_cls),
        .conflict (conflict)
    );

    csd_class_match #(.N_ENG(N_ENG), .C_W(C_W)) u_match (
        .cls     (bound_cls),
        .hit_vec (hit_vec),
        .hit     (hit)
    );

    assign eng_valid  = (issue && is_eng && bound) ? hit_vec : '0;
    assign eng_method = pend_method;
    assign eng_value  = pend_value;
    assign issue_done = issue && (!is_eng || !bound || !hit || |(hit_vec & eng_ready));

    assign err_rebind    = conflict;
    assign err_reserved  = issue && is_resv;
    assign err_unbound   = issue && is_eng && !bound;
    assign err_bad_class = issue && is_eng && bound && !hit;

    a_r8_onehot_dispatch: assert property (@(posedge clk) disable iff (rst)
        $onehot0(eng_valid));

    a_r11_hold_write: assert property (@(posedge clk) disable iff (rst)
        (|eng_valid && !(|(eng_valid & eng_ready)))
        |=> ($stable(eng_valid) && $stable(eng_method) && $stable(eng_value)));

    a_r11_stall_input: assert property (@(posedge clk) disable iff (rst)
        (|eng_valid) |-> !in_ready);

    a_r7_reserved_dropped: assert property (@(posedge clk) disable iff (rst)
        err_reserved |-> (eng_valid == '0));
endmodule

// File: tb/test_cmd_stream_decoder.sv
module test_cmd_stream_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic [2:0]  eng_valid;
    logic [2:0]  eng_ready = 3'b111;
    logic [12:0] eng_method;
    logic [31:0] eng_value;
    logic e_mode, e_zero, e_rebind, e_resv, e_unb, e_cls;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    cmd_stream_decoder i_cmd_stream_decoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
        .eng_valid(eng_valid), .eng_ready(eng_ready), .eng_method(eng_method),
        .eng_value(eng_value), .err_bad_mode(e_mode), .err_zero_count(e_zero),
        .err_rebind(e_rebind), .err_reserved(e_resv), .err_unbound(e_unb),
        .err_bad_class(e_cls)
    );

    // ready pattern: all ones or pseudo-random
    logic [15:0] lfsr = 16'hACE1;
    bit rand_ready = 0;
    always @(posedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        eng_ready <= rand_ready ? lfsr[2:0] : 3'b111;
    end

    // expected event queues: kind 0 write, 1 mode, 2 zero, 3 rebind, 4 reserved, 5 unbound, 6 class
    int    q_kind[$];
    int    q_eng[$];
    int    q_meth[$];
    int    q_val[$];
    string q_req[$];

    // behavioural model state
    bit m_hdr = 1;
    int m_mode, m_base, m_sub, m_left, m_idx;
    bit m_bound[8];
    int m_cls[8];

    task automatic push(int k, int e, int m, int v, string r);
        q_kind.push_back(k); q_eng.push_back(e); q_meth.push_back(m);
        q_val.push_back(v); q_req.push_back(r);
    endtask

    task automatic m_write(int meth, int sub, int val, string tag);
        int c;
        if (meth == 0) begin
            if (m_bound[sub]) push(3, 0, 0, 0, "R6");
            else begin m_bound[sub] = 1; m_cls[sub] = val & 16'hFFFF; end
        end else if (meth < 256) push(4, 0, 0, 0, "R7");
        else if (!m_bound[sub]) push(5, 0, 0, 0, "R9");
        else begin
            c = m_cls[sub];
            if (c == 16'h902D)      push(0, 0, meth, val, tag);
            else if (c == 16'hB197) push(0, 1, meth, val, tag);
            else if (c == 16'hB1C0) push(0, 2, meth, val, tag);
            else                    push(6, 0, 0, 0, "R9");
        end
    endtask

    task automatic m_feed(logic [31:0] w);
        int meth;
        if (m_hdr) begin
            m_mode = int'(w[31:29]); m_base = int'(w[12:0]);
            m_sub = int'(w[15:13]); m_left = int'(w[28:16]); m_idx = 0;
            if (m_mode >= 6) push(1, 0, 0, 0, "R10");
            else if (m_mode == 4) m_write(m_base, m_sub, m_left, "R4");
            else if (m_mode == 5 && m_left == 0) push(2, 0, 0, 0, "R3");
            else if (m_left > 0) m_hdr = 0;
        end else begin
            if (m_mode <= 1)      meth = (m_base + m_idx) & 13'h1FFF;
            else if (m_mode <= 3) meth = m_base;
            else                  meth = (m_idx == 0) ? m_base : ((m_base + 1) & 13'h1FFF);
            m_write(meth, m_sub, int'(w), (m_mode <= 1) ? "R1" : (m_mode <= 3) ? "R2" : "R3");
            m_idx++; m_left--;
            if (m_left == 0) m_hdr = 1;
        end
    endtask

    function automatic logic [31:0] hdr(int mode, int cnt, int sub, int meth);
        logic [2:0] md = mode[2:0];
        logic [12:0] ct = cnt[12:0];
        logic [2:0] sb = sub[2:0];
        logic [12:0] mt = meth[12:0];
        return {md, ct, sb, mt};
    endfunction

    task automatic send(logic [31:0] w);
        in_valid = 1'b1;
        in_word  = w;
        while (!in_ready) @(negedge clk);
        m_feed(w);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic bind_sub(int sub, int cls);
        send(hdr(1, 1, sub, 0));
        send(cls);
    endtask

    task automatic drain();
        for (int i = 0; i < 2000 && q_kind.size() != 0; i++) @(negedge clk);
        checks++;
        if (q_kind.size() != 0) begin
            fails++;
            $display("FAIL R8 pending events: actual %0d expected 0", q_kind.size());
        end
    endtask

    task automatic reset_check();
        checks++;
        if (in_ready !== 1'b1 || eng_valid !== 3'b000 ||
            {e_mode, e_zero, e_rebind, e_resv, e_unb, e_cls} !== 6'b0) begin
            fails++;
            $display("FAIL R12 after reset: actual ready=%b valid=%b flags=%b expected 1 000 000000",
                     in_ready, eng_valid, {e_mode, e_zero, e_rebind, e_resv, e_unb, e_cls});
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        m_hdr = 1;
        for (int s = 0; s < 8; s++) begin m_bound[s] = 0; m_cls[s] = 0; end
        rst = 1'b0;
        @(negedge clk);
        reset_check();
    endtask

    // monitor, compared every clock
    logic [2:0]  p_valid = '0, p_ready = '0;
    logic [12:0] p_meth = '0;
    logic [31:0] p_val = '0;
    always @(negedge clk) begin
        if (!rst) begin
            int k, n, e;
            k = -1; n = 0; e = 0;
            for (int i = 0; i < 3; i++)
                if (eng_valid[i] && eng_ready[i]) begin k = 0; e = i; n++; end
            if (e_mode)   begin k = 1; n++; end
            if (e_zero)   begin k = 2; n++; end
            if (e_rebind) begin k = 3; n++; end
            if (e_resv)   begin k = 4; n++; end
            if (e_unb)    begin k = 5; n++; end
            if (e_cls)    begin k = 6; n++; end
            if (n > 1) begin
                checks++; fails++;
                $display("FAIL R8 events in one cycle: actual %0d expected 1", n);
            end else if (k >= 0) begin
                checks++;
                if (q_kind.size() == 0) begin
                    fails++;
                    $display("FAIL R8 unexpected event: actual kind %0d expected none", k);
                end else begin
                    int xk, xe, xm, xv; string xr;
                    xk = q_kind.pop_front(); xe = q_eng.pop_front(); xm = q_meth.pop_front();
                    xv = q_val.pop_front(); xr = q_req.pop_front();
                    if (k != xk || (k == 0 && (e != xe || int'(eng_method) != xm ||
                                               eng_value != 32'(xv)))) begin
                        fails++;
                        $display("FAIL %s R8 event: actual kind %0d eng %0d meth %h val %h expected kind %0d eng %0d meth %h val %h",
                                 xr, k, e, eng_method, eng_value, xk, xe, xm, xv);
                    end
                end
            end
            if (p_valid != 0 && (p_valid & p_ready) == 0) begin
                checks++;
                if (eng_valid != p_valid || eng_method != p_meth || eng_value != p_val) begin
                    fails++;
                    $display("FAIL R11 hold: actual %b/%h/%h expected %b/%h/%h",
                             eng_valid, eng_method, eng_value, p_valid, p_meth, p_val);
                end
            end
            if (eng_valid != 0 && in_ready) begin
                checks++; fails++;
                $display("FAIL R11 in_ready during stall: actual 1 expected 0");
            end
        end
        p_valid = rst ? 3'b0 : eng_valid; p_ready = eng_ready;
        p_meth = eng_method; p_val = eng_value;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        for (int s = 0; s < 8; s++) begin m_bound[s] = 0; m_cls[s] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        reset_check();

        // R5 bindings
        bind_sub(0, 32'h0001_902D);
        bind_sub(1, 32'hB197);
        bind_sub(2, 32'hB1C0);
        bind_sub(3, 32'h1234);
        // R1 incrementing
        send(hdr(1, 4, 0, 13'h200));
        for (int i = 0; i < 4; i++) send(32'hA000_0000 + i);
        send(hdr(0, 2, 1, 13'h1FFF));   // wraps to 0x000 -> R6 path on bound sub1
        send(32'h11); send(32'h22);
        send(hdr(1, 0, 0, 13'h300));    // empty
        // R2 fixed
        send(hdr(3, 3, 2, 13'h300));
        for (int i = 0; i < 3; i++) send(32'hB000_0000 + i);
        send(hdr(2, 1, 0, 13'h1234)); send(32'hCAFE_F00D);
        drain();

        rand_ready = 1;
        // R3 increment-once
        send(hdr(5, 4, 1, 13'h400));
        for (int i = 0; i < 4; i++) send(32'hC000_0000 + i);
        send(hdr(5, 1, 2, 13'h410)); send(32'hD00D);
        send(hdr(5, 0, 2, 13'h420));
        // R4 inline
        send(hdr(4, 13'h1ABC, 2, 13'h150));
        send(hdr(4, 0, 0, 13'h1FFF));
        // R7 reserved, crossing into engine methods
        send(hdr(4, 5, 0, 13'h080));
        send(hdr(1, 3, 0, 13'h0FE));
        send(32'h1); send(32'h2); send(32'h3);
        bind_sub(4, 32'h902D);
        send(hdr(1, 2, 4, 0)); send(32'hB197); send(32'h77);
        // R6 rebind keeps old class
        bind_sub(0, 32'hB197);
        send(hdr(4, 9, 0, 13'h600));
        // R9 unbound / unknown class
        send(hdr(4, 1, 5, 13'h700));
        send(hdr(4, 2, 3, 13'h700));
        // R10 bad modes
        send(hdr(6, 2, 0, 13'h200));
        send(hdr(7, 0, 1, 13'h200));
        send(hdr(4, 3, 1, 13'h800));
        // long stall run
        send(hdr(1, 20, 2, 13'h900));
        for (int i = 0; i < 20; i++) send(32'hE000_0000 + i);
        drain();

        // R12 reset mid command
        rand_ready = 0;
        send(hdr(1, 3, 2, 13'h500)); send(32'h55);
        drain();
        do_reset();
        send(hdr(4, 7, 2, 13'h510));   // now unbound, taken as header
        drain();
        bind_sub(2, 32'hB1C0);
        send(hdr(4, 8, 2, 13'h520));
        drain();

        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule